// File: doc/BRIEF.md
# Word-Interleaved Banked Memory Controller

This block sits in front of sixteen single-ported memory banks, each of which needs eleven cycles to finish an access. Word addresses are spread across the banks by their lowest four bits, so neighbouring words land in different banks. Because there are more banks than cycles of latency, a stream of consecutive words can start a new access on every cycle, and the long bank latency is hidden.

A requester offers at most one request per cycle: a read or write flag, a word address, write data and a tag. The request is taken when `req_ready` is high. `req_ready` depends only on whether the addressed bank is still working on an earlier access. A request that hits a busy bank is held off until that bank is free. Requests are taken strictly in the order offered. A read returns its data together with its tag a fixed number of cycles after it was taken. Since every access has the same latency and only one can start per cycle, responses come back in issue order. A write gives no response.

Top module: `interleaved_bank_ctrl`

## Requirements
- R1: The bank is the low 4 bits of the word address (`req_addr[3:0]`), and the row inside the bank is `req_addr >> 4`. Every one of the 1024 word addresses holds its own independent word.
- R2: At most one request is taken per cycle. A request is taken in a cycle where both `req_valid` and `req_ready` are high.
- R3: A read taken in cycle c drives `rsp_valid` high for exactly one cycle, in cycle c+11. In every other cycle `rsp_valid` is low unless another read is due.
- R4: A bank that took a request in cycle c holds `req_ready` low for requests to that bank during cycles c+1 to c+10. It can take a new request in cycle c+11.
- R5: `req_ready` for an address whose bank is idle is high, whatever the other banks are doing.
- R6: A unit-stride sequence of requests, with the banks idle at the start, is taken at one request per cycle: N requests take N cycles.
- R7: `rsp_tag` carries the tag of the read being answered. Responses come out in the order the reads were taken.
- R8: A taken write produces no response. `rsp_valid` stays low in the cycle where a read would have answered.
- R9: After reset, `req_ready` is high for every address and `rsp_valid` is low.
- R10: A read returns the data of the most recent write to the same address that was taken before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered this cycle |
| req_ready | output | 1 | The addressed bank is free, so the request is taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (10) | Word address; the low 4 bits select the bank |
| req_wdata | input | DATA_W (32) | Write data |
| req_tag | input | TAG_W (6) | Tag returned with read data |
| rsp_valid | output | 1 | Read response present this cycle |
| rsp_tag | output | TAG_W (6) | Tag of the answered read |
| rsp_rdata | output | DATA_W (32) | Data of the answered read |

## Verification
Faults in the per-bank countdown show up at `req_ready`. A counter loaded one cycle short or one cycle long makes the bank accept or refuse a request to the same bank in exactly the wrong cycle, at c+10 or c+11. Faults in the bank selection or row mapping show up as wrong read data, at the earliest when a written address is read back. A broken completion path shows up as a response one cycle off the c+11 slot, or as a tag that does not match the oldest outstanding read, in the cycle the response is due. The reference model predicts `req_ready` and the response every cycle, so each of these faults is reported in the first cycle where it becomes visible at the ports.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
   // Activity of one bank while its countdown runs.
   typedef enum logic [1:0] {
      BANK_IDLE  = 2'd0,
      BANK_READ  = 2'd1,
      BANK_WRITE = 2'd2
   } bank_state_e;

   // Default geometry shared by the controller and its checker.
   localparam int DEF_NUM_BANKS = 16;
   localparam int DEF_LATENCY   = 11;
   localparam int DEF_ADDR_W    = 10;
   localparam int DEF_DATA_W    = 32;
   localparam int DEF_TAG_W     = 6;
endpackage

// File: rtl/ibc_bank.sv
module ibc_bank
   import ibc_pkg::*;
#(
   parameter int DATA_W  = DEF_DATA_W,
   parameter int TAG_W   = DEF_TAG_W,
   parameter int ROW_W   = 6,
   parameter int LATENCY = DEF_LATENCY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              write_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [TAG_W-1:0]  tag_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [TAG_W-1:0]  tag_o
);
   localparam int ROWS  = 1 << ROW_W;
   localparam int CNT_W = $clog2(LATENCY);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LATENCY - 1);

   logic [DATA_W-1:0] mem [ROWS];
   logic [CNT_W-1:0]  remain_q;
   bank_state_e       state_q;
   logic [DATA_W-1:0] hold_q;
   logic [TAG_W-1:0]  tag_q;

   // Storage: written in the cycle the access starts.
   always_ff @(posedge clk) begin
      if (start_i && write_i) begin
         mem[row_i] <= wdata_i;
      end
   end

   // Read data and tag are captured at start and held until completion.
   always_ff @(posedge clk) begin
      if (start_i) begin
         hold_q <= mem[row_i];
         tag_q  <= tag_i;
      end
   end

   // Countdown of remaining busy cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         state_q  <= BANK_IDLE;
      end else if (start_i) begin
         remain_q <= LOAD_VAL;
         state_q  <= write_i ? BANK_WRITE : BANK_READ;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
         if (remain_q == CNT_W'(1)) begin
            state_q <= BANK_IDLE;
         end
      end
   end

   assign busy_o  = (remain_q != '0);
   assign done_o  = (remain_q == CNT_W'(1)) && (state_q == BANK_READ);
   assign rdata_o = hold_q;
   assign tag_o   = tag_q;
endmodule

// File: rtl/ibc_rsp_merge.sv
module ibc_rsp_merge
   import ibc_pkg::*;
#(
   parameter int NUM_BANKS = DEF_NUM_BANKS,
   parameter int DATA_W    = DEF_DATA_W,
   parameter int TAG_W     = DEF_TAG_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_BANKS-1:0]              done_i,
   input  logic [NUM_BANKS-1:0][DATA_W-1:0]  data_i,
   input  logic [NUM_BANKS-1:0][TAG_W-1:0]   tag_i,
   output logic                              rsp_valid_o,
   output logic [TAG_W-1:0]                  rsp_tag_o,
   output logic [DATA_W-1:0]                 rsp_data_o
);
   logic              any_done;
   logic [DATA_W-1:0] sel_data;
   logic [TAG_W-1:0]  sel_tag;

   // At most one bank finishes a read per cycle, so an OR-mux suffices.
   always_comb begin
      any_done = 1'b0;
      sel_data = '0;
      sel_tag  = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (done_i[b]) begin
            any_done = 1'b1;
            sel_data = sel_data | data_i[b];
            sel_tag  = sel_tag  | tag_i[b];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_tag_o   <= '0;
         rsp_data_o  <= '0;
      end else begin
         rsp_valid_o <= any_done;
         if (any_done) begin
            rsp_tag_o  <= sel_tag;
            rsp_data_o <= sel_data;
         end
      end
   end
endmodule

// File: rtl/interleaved_bank_ctrl.sv
module interleaved_bank_ctrl
   import ibc_pkg::*;
#(
   parameter int NUM_BANKS = DEF_NUM_BANKS,
   parameter int LATENCY   = DEF_LATENCY,
   parameter int ADDR_W    = DEF_ADDR_W,
   parameter int DATA_W    = DEF_DATA_W,
   parameter int TAG_W     = DEF_TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int SEL_W = $clog2(NUM_BANKS);
   localparam int ROW_W = ADDR_W - SEL_W;

   // Elaboration-time parameter checks.
   if (NUM_BANKS < 2 || (1 << SEL_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (LATENCY < 2) begin : g_bad_latency
      $error("LATENCY must be at least 2");
   end
   if (ROW_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the bank-select width");
   end

   logic [SEL_W-1:0]                   bank_sel;
   logic [ROW_W-1:0]                   bank_row;
   logic                               accept;
   logic [NUM_BANKS-1:0]               bank_busy;
   logic [NUM_BANKS-1:0]               bank_done;
   logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_rdata;
   logic [NUM_BANKS-1:0][TAG_W-1:0]    bank_tag;

   // Word interleave: low bits pick the bank, the rest pick the row.
   assign bank_sel  = req_addr[SEL_W-1:0];
   assign bank_row  = req_addr[ADDR_W-1:SEL_W];
   assign req_ready = !bank_busy[bank_sel];
   assign accept    = req_valid && req_ready;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic start_b;
      assign start_b = accept && (bank_sel == SEL_W'(b));

      ibc_bank #(
         .DATA_W (DATA_W),
         .TAG_W  (TAG_W),
         .ROW_W  (ROW_W),
         .LATENCY(LATENCY)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .start_i(start_b),
         .write_i(req_write),
         .row_i  (bank_row),
         .wdata_i(req_wdata),
         .tag_i  (req_tag),
         .busy_o (bank_busy[b]),
         .done_o (bank_done[b]),
         .rdata_o(bank_rdata[b]),
         .tag_o  (bank_tag[b])
      );
   end

   ibc_rsp_merge #(
      .NUM_BANKS(NUM_BANKS),
      .DATA_W   (DATA_W),
      .TAG_W    (TAG_W)
   ) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (bank_done),
      .data_i     (bank_rdata),
      .tag_i      (bank_tag),
      .rsp_valid_o(rsp_valid),
      .rsp_tag_o  (rsp_tag),
      .rsp_data_o (rsp_rdata)
   );
endmodule

// File: rtl/ibc_checker.sv
module ibc_checker #(
   parameter int NUM_BANKS = 16,
   parameter int LATENCY   = 11,
   parameter int ADDR_W    = 10,
   parameter int TAG_W     = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic                 req_write,
   input logic [ADDR_W-1:0]    req_addr,
   input logic [TAG_W-1:0]     req_tag,
   input logic                 rsp_valid,
   input logic [TAG_W-1:0]     rsp_tag,
   input logic [NUM_BANKS-1:0] bank_done
);
   localparam int SEL_W = $clog2(NUM_BANKS);

   logic                  take;
   logic [LATENCY-1:0]    rd_pipe;
   logic [LATENCY-1:0]    wr_pipe;
   logic [TAG_W-1:0]      tag_pipe [LATENCY];

   assign take = req_valid && req_ready;

   // Shadow delay line: one slot per cycle of bank latency.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pipe <= '0;
         wr_pipe <= '0;
         for (int i = 0; i < LATENCY; i++) tag_pipe[i] <= '0;
      end else begin
         rd_pipe     <= {rd_pipe[LATENCY-2:0], take && !req_write};
         wr_pipe     <= {wr_pipe[LATENCY-2:0], take && req_write};
         tag_pipe[0] <= req_tag;
         for (int i = 1; i < LATENCY; i++) tag_pipe[i] <= tag_pipe[i-1];
      end
   end

   assert_single_completion_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_done));

   assert_rsp_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == rd_pipe[LATENCY-1]);

   assert_same_bank_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !(req_ready && (req_addr[SEL_W-1:0] == $past(req_addr[SEL_W-1:0]))));

   assert_rsp_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_tag == tag_pipe[LATENCY-1]));

   assert_write_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pipe[LATENCY-1] |-> !rsp_valid);
endmodule

bind interleaved_bank_ctrl ibc_checker #(
   .NUM_BANKS(NUM_BANKS),
   .LATENCY  (LATENCY),
   .ADDR_W   (ADDR_W),
   .TAG_W    (TAG_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_write(req_write),
   .req_addr (req_addr),
   .req_tag  (req_tag),
   .rsp_valid(rsp_valid),
   .rsp_tag  (rsp_tag),
   .bank_done(bank_done)
);

// File: tb/tb_interleaved_bank_ctrl.sv
module tb_interleaved_bank_ctrl;
   localparam int NB   = 16;
   localparam int LAT  = 11;
   localparam int AW   = 10;
   localparam int DW   = 32;
   localparam int TW   = 6;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [TW-1:0] req_tag = '0;
   logic          rsp_valid;
   logic [TW-1:0] rsp_tag;
   logic [DW-1:0] rsp_rdata;

   always #2 clk = ~clk;

   interleaved_bank_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_rdata(rsp_rdata)
   );

   // Behavioural reference model.
   int            n_checks = 0;
   int            n_fail = 0;
   bit            done_flag = 0;
   int            cyc = 0;
   int            free_at [NB];
   logic [DW-1:0] ref_mem [WORDS];
   int            due_q [$];
   logic [TW-1:0] tag_q [$];
   logic [DW-1:0] dat_q [$];
   bit            last_taken;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // One clock cycle: compare outputs, then advance the model at the edge.
   task automatic step();
      bit exp_ready;
      bit exp_rsp;
      #1;
      exp_ready = (cyc >= free_at[req_addr[3:0]]);
      chk(req_ready == exp_ready, "R4/R5", "req_ready", 64'(req_ready), 64'(exp_ready));
      exp_rsp = (due_q.size() > 0) && (due_q[0] == cyc);
      chk(rsp_valid == exp_rsp, "R3/R8", "rsp_valid", 64'(rsp_valid), 64'(exp_rsp));
      if (exp_rsp && rsp_valid) begin
         chk(rsp_tag == tag_q[0], "R7", "rsp_tag", 64'(rsp_tag), 64'(tag_q[0]));
         chk(rsp_rdata == dat_q[0], "R10", "rsp_rdata", 64'(rsp_rdata), 64'(dat_q[0]));
      end
      if (exp_rsp) begin
         void'(due_q.pop_front());
         void'(tag_q.pop_front());
         void'(dat_q.pop_front());
      end
      @(posedge clk);
      last_taken = req_valid && exp_ready;
      if (last_taken) begin
         free_at[req_addr[3:0]] = cyc + LAT;
         if (req_write) begin
            ref_mem[req_addr] = req_wdata;
         end else begin
            due_q.push_back(cyc + LAT);
            tag_q.push_back(req_tag);
            dat_q.push_back(ref_mem[req_addr]);
         end
      end
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      req_valid = 1'b0;
      for (int i = 0; i < n; i++) step();
   endtask

   // Offer a request until taken; returns the cycle it was taken in.
   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [TW-1:0] t, output int at);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_tag = t;
      at = -1;
      while (at < 0) begin
         at = cyc;
         step();
         if (!last_taken) at = -1;
      end
      req_valid = 1'b0;
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'(32'h9E37_79B9 * (a + 1)) ^ DW'(a << 20);
   endfunction

   initial begin
      int t0, t1, t2;
      for (int b = 0; b < NB; b++) free_at[b] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state, every address ready, no response.
      for (int a = 0; a < WORDS; a += 37) begin
         req_addr = AW'(a);
         #1;
         chk(req_ready == 1'b1, "R9", "ready after reset", 64'(req_ready), 64'd1);
      end
      chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 64'(rsp_valid), 64'd0);

      // R6, R1, R8: fill every word with a unit-stride write stream.
      t0 = cyc;
      req_valid = 1'b1; req_write = 1'b1;
      for (int a = 0; a < WORDS; a++) begin
         req_addr = AW'(a); req_wdata = pat(a); req_tag = TW'(a);
         step();
         while (!last_taken) step();
      end
      req_valid = 1'b0;
      chk(cyc - t0 == WORDS, "R6", "write stream cycles", 64'(cyc - t0), 64'(WORDS));
      idle(LAT + 2);

      // R6, R7, R1: unit-stride read stream with tags, across row boundaries.
      t0 = cyc;
      req_valid = 1'b1; req_write = 1'b0;
      for (int i = 0; i < 64; i++) begin
         req_addr = AW'(200 + i); req_tag = TW'(i);
         step();
         while (!last_taken) step();
      end
      req_valid = 1'b0;
      chk(cyc - t0 == 64, "R6", "read stream cycles", 64'(cyc - t0), 64'd64);
      idle(LAT + 2);

      // R4: same-bank back-to-back stalls until cycle c+11.
      issue(1'b0, AW'(5), '0, TW'(1), t1);
      issue(1'b0, AW'(21), '0, TW'(2), t2);
      chk(t2 - t1 == LAT, "R4", "same-bank gap", 64'(t2 - t1), 64'(LAT));
      idle(LAT + 2);

      // R5: other banks are taken at once while one bank is busy.
      issue(1'b0, AW'(7), '0, TW'(3), t1);
      issue(1'b0, AW'(8), '0, TW'(4), t2);
      chk(t2 - t1 == 1, "R5", "other-bank gap", 64'(t2 - t1), 64'd1);
      issue(1'b0, AW'(9), '0, TW'(5), t2);
      chk(t2 - t1 == 2, "R5", "third-bank gap", 64'(t2 - t1), 64'd2);
      idle(LAT + 2);

      // R10, R8, R1: write then read same address; neighbour row untouched.
      issue(1'b1, AW'(300), 32'hDEAD_BEEF, TW'(6), t1);
      issue(1'b0, AW'(300), '0, TW'(7), t2);
      chk(t2 - t1 == LAT, "R4", "write-read gap", 64'(t2 - t1), 64'(LAT));
      issue(1'b0, AW'(316), '0, TW'(8), t2);
      idle(2 * LAT + 2);

      // R2, R3, R7, R10: random mixed traffic, model checked every cycle.
      for (int i = 0; i < 3000; i++) begin
         req_valid = ($urandom % 4) != 0;
         req_write = ($urandom % 3) == 0;
         req_addr  = ($urandom % 2) ? AW'($urandom) : AW'(i);
         req_wdata = DW'($urandom);
         req_tag   = TW'(i);
         step();
      end
      idle(2 * LAT);
      chk(due_q.size() == 0, "R3", "outstanding reads", 64'(due_q.size()), 64'd0);

      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done_flag) begin
         done_flag = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule